// File: doc/BRIEF.md
# Dual-Channel Converter Input Interleaver

This block is the digital front end of a two-channel 14-bit converter. It takes sample words either on two independent parallel ports, or on one shared port that carries alternating I and Q words. It delivers a matched pair of codes to two output registers that stand in for the converter cores. Each output code also comes with its complement, and a registered power-down flag is driven from the sleep input.

All strobe pins are level signals sampled by the system clock `clk`. A strobe acts on the clock edge at which its new level is first seen. In dual-bus mode each channel has its own write strobe and its own update clock. In shared-port mode one write strobe, one select line, one update clock and one pairing reset serve both channels. Two of these shared functions reuse the channel-B strobe pins. The shared update clock is divided by two by a small state machine. Its states are DIV_HELD, DIV_LOW and DIV_HIGH, and its transitions are:

- any state to DIV_HELD while the pairing reset is high or the block is in dual-bus mode;
- DIV_HELD or DIV_LOW to DIV_HIGH on an update rise, which is the core update;
- DIV_HELD to DIV_LOW when there is no update rise;
- DIV_HIGH to DIV_LOW on an update rise, which is the skipped edge.

Each channel feeds its output register through a pipeline of update stages. A captured word reaches the output at the fourth core update after it becomes available.

Top module: `dac_pair_front`

## Requirements
- R1: `mode_sel` is sampled only while `rst_n` is low. 1 selects dual-bus mode and 0 selects shared-port mode. Changes to `mode_sel` after reset have no effect.
- R2: In dual-bus mode, a rising level on `wrt_a` (or `wrt_b_sel`) captures `din_a` (or `din_b`) into that channel's input register.
- R3: In dual-bus mode, each rising level on `upd_a` (or `upd_b_prst`) advances only that channel. A word captured before an update rise appears on the code output after the fourth update rise of that channel, counting that rise. A write and an update that rise together count the update against the previously held word.
- R4: In shared-port mode, a rising level on `wrt_a` captures `din_a`. The word goes into the channel A input register when `wrt_b_sel` is 1 and into the channel B input register when it is 0. `din_b` has no effect.
- R5: In shared-port mode, the input register that is not selected keeps its value.
- R6: In shared-port mode, both input registers are copied to the pipeline inputs on the falling level of `wrt_a`.
- R7: In shared-port mode, only every second rising level of `upd_a` advances both channels together. The first rise after release of the pairing reset is a core update.
- R8: In shared-port mode, while `upd_b_prst` is 1 no core update occurs and the divider returns to its held phase.
- R9: In shared-port mode, a handed-off pair appears on both outputs after the fourth core update that follows the handoff.
- R10: `code_a_n` and `code_b_n` always equal 16383 minus `code_a` and `code_b` respectively. Codes are unsigned offset binary with bit 13 as the MSB.
- R11: While `sleep` is 1, no update of any kind takes place, so both outputs are frozen. Write captures continue. `pwr_down` follows `sleep` one clock later.
- R12: After reset both codes are 0, both complements are 16383 and `pwr_down` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low reset; `mode_sel` is sampled while it is low |
| mode_sel | input | 1 | 1 = dual-bus, 0 = shared-port |
| sleep | input | 1 | Power-down request, active high |
| wrt_a | input | 1 | Write strobe for channel A, or shared write strobe |
| wrt_b_sel | input | 1 | Write strobe for channel B, or channel select in shared-port mode |
| upd_a | input | 1 | Update clock for channel A, or shared update clock |
| upd_b_prst | input | 1 | Update clock for channel B, or pairing reset in shared-port mode |
| din_a | input | 14 | Channel A data bus, or shared data bus |
| din_b | input | 14 | Channel B data bus |
| code_a | output | 14 | Channel A output code |
| code_b | output | 14 | Channel B output code |
| code_a_n | output | 14 | Complement of channel A code |
| code_b_n | output | 14 | Complement of channel B code |
| pwr_down | output | 1 | Registered power-down flag |

## Verification
On every cycle, the assertions check the following:

- a code moves only one clock after an update rise on its own channel in dual-bus mode, or after an unblocked shared update rise in shared-port mode;
- a high pairing reset or a high sleep input freezes both codes;
- the power-down flag tracks sleep.

Only the bench scenarios can show the following:

- the four-update latency;
- the divide-by-two pairing of A and B words;
- the misaligned pair that results when the divider phase is shifted, which also shows that the unselected register holds its value;
- the insensitivity to `din_b` and to late changes of `mode_sel`.

// File: rtl/dacpf_pkg.sv
package dacpf_pkg;

    typedef enum logic {
        MODE_SHARED = 1'b0,
        MODE_DUAL   = 1'b1
    } bus_mode_t;

    typedef enum logic [1:0] {
        DIV_HELD = 2'd0,
        DIV_LOW  = 2'd1,
        DIV_HIGH = 2'd2
    } div_state_t;

    localparam int STB_WR_A = 0;
    localparam int STB_WR_B = 1;
    localparam int STB_UP_A = 2;
    localparam int STB_UP_B = 3;
    localparam int NUM_STB  = 4;

endpackage

// File: rtl/dacpf_strobe_hist.sv
module dacpf_strobe_hist #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] prev
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev[i] <= 1'b0;
                end else begin
                    prev[i] <= pin[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dacpf_capture.sv
module dacpf_capture
    import dacpf_pkg::*;
#(
    parameter int W = 14
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_t mode,
    input  logic      cap_a,
    input  logic      cap_b,
    input  logic      handoff,
    input  logic      sel,
    input  logic [W-1:0] din_a,
    input  logic [W-1:0] din_b,
    output logic [W-1:0] word_a,
    output logic [W-1:0] word_b
);

    logic [W-1:0] hold_a, hold_b;
    logic [W-1:0] hold_a_nx, hold_b_nx;
    logic [W-1:0] pass_a, pass_b;

    // Input registers: default next value is the register itself (feedback hold)
    always_comb begin
        hold_a_nx = hold_a;
        hold_b_nx = hold_b;
        unique case (mode)
            MODE_DUAL: begin
                if (cap_a) hold_a_nx = din_a;
                if (cap_b) hold_b_nx = din_b;
            end
            MODE_SHARED: begin
                if (cap_a) begin
                    if (sel) hold_a_nx = din_a;
                    else     hold_b_nx = din_a;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_a <= '0;
            hold_b <= '0;
        end else begin
            hold_a <= hold_a_nx;
            hold_b <= hold_b_nx;
        end
    end

    // Handoff registers: loaded on the falling write level in shared-port mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_a <= '0;
            pass_b <= '0;
        end else if (mode == MODE_SHARED && handoff) begin
            pass_a <= hold_a;
            pass_b <= hold_b;
        end
    end

    assign word_a = (mode == MODE_DUAL) ? hold_a : pass_a;
    assign word_b = (mode == MODE_DUAL) ? hold_b : pass_b;

endmodule

// File: rtl/dacpf_pair_div.sv
module dacpf_pair_div
    import dacpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic pair_hold,
    output logic core_evt
);

    div_state_t state_q, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_HELD;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        if (!active || pair_hold) begin
            state_nx = DIV_HELD;
        end else begin
            unique case (state_q)
                DIV_HELD: state_nx = tick ? DIV_HIGH : DIV_LOW;
                DIV_LOW:  state_nx = tick ? DIV_HIGH : DIV_LOW;
                DIV_HIGH: state_nx = tick ? DIV_LOW  : DIV_HIGH;
                default:  state_nx = DIV_HELD;
            endcase
        end
    end

    // Outputs: a core update is the rising half of the divided clock
    always_comb begin
        core_evt = 1'b0;
        if (active && !pair_hold && tick) begin
            unique case (state_q)
                DIV_HELD, DIV_LOW: core_evt = 1'b1;
                DIV_HIGH:          core_evt = 1'b0;
                default:           core_evt = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dacpf_core_pipe.sv
module dacpf_core_pipe #(
    parameter int W     = 14,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stg
            if (s == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)   stg[0] <= '0;
                    else if (adv) stg[0] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)   stg[s] <= '0;
                    else if (adv) stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/dac_pair_front.sv
module dac_pair_front
    import dacpf_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              sleep,
    input  logic              wrt_a,
    input  logic              wrt_b_sel,
    input  logic              upd_a,
    input  logic              upd_b_prst,
    input  logic [DATA_W-1:0] din_a,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic [DATA_W-1:0] code_a_n,
    output logic [DATA_W-1:0] code_b_n,
    output logic              pwr_down
);

    localparam int                NCH      = 2;
    localparam logic [DATA_W-1:0] CODE_MAX = '1;

    bus_mode_t          mode_q;
    logic [NUM_STB-1:0] pins, prev, rise;
    logic               wr_fall;
    logic               core_evt;
    logic [DATA_W-1:0]  word [NCH];
    logic [DATA_W-1:0]  code [NCH];
    logic [NCH-1:0]     adv;
    logic [NCH-1:0]     own_up;

    // Mode is taken only while held in reset
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= bus_mode_t'(mode_sel);
    end

    assign pins = {upd_b_prst, upd_a, wrt_b_sel, wrt_a};

    dacpf_strobe_hist #(.N(NUM_STB)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pins),
        .prev  (prev)
    );

    assign rise    = pins & ~prev;
    assign wr_fall = prev[STB_WR_A] & ~pins[STB_WR_A];

    dacpf_capture #(.W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .cap_a   (rise[STB_WR_A]),
        .cap_b   (rise[STB_WR_B]),
        .handoff (wr_fall),
        .sel     (wrt_b_sel),
        .din_a   (din_a),
        .din_b   (din_b),
        .word_a  (word[0]),
        .word_b  (word[1])
    );

    dacpf_pair_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mode_q == MODE_SHARED),
        .tick      (rise[STB_UP_A] & ~sleep),
        .pair_hold (upd_b_prst),
        .core_evt  (core_evt)
    );

    assign own_up = {rise[STB_UP_B], rise[STB_UP_A]};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            assign adv[ch] = ~sleep & ((mode_q == MODE_DUAL) ? own_up[ch] : core_evt);

            dacpf_core_pipe #(.W(DATA_W), .DEPTH(LATENCY)) u_pipe (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (adv[ch]),
                .din   (word[ch]),
                .dout  (code[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_down <= 1'b0;
        else        pwr_down <= sleep;
    end

    assign code_a   = code[0];
    assign code_b   = code[1];
    assign code_a_n = CODE_MAX - code[0];
    assign code_b_n = CODE_MAX - code[1];

endmodule

// File: rtl/dac_pair_front_chk.sv
module dac_pair_front_chk
    import dacpf_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              upd_a,
    input logic              upd_b_prst,
    input bus_mode_t         mode_q,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              pwr_down
);

    logic ua_q, ub_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ua_q <= 1'b0;
            ub_q <= 1'b0;
        end else begin
            ua_q <= upd_a;
            ub_q <= upd_b_prst;
        end
    end

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(code_a) && $stable(code_b)));  // R11

    AST_PWR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> pwr_down);  // R11

    AST_PWR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !pwr_down);  // R11

    AST_DUAL_A_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL && !$stable(code_a)) |-> $past(upd_a && !ua_q));  // R3

    AST_DUAL_B_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL && !$stable(code_b)) |-> $past(upd_b_prst && !ub_q));  // R3

    AST_SHARED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SHARED && (!$stable(code_a) || !$stable(code_b)))
            |-> $past(upd_a && !ua_q && !upd_b_prst));  // R7

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SHARED && upd_b_prst) |=> ($stable(code_a) && $stable(code_b)));  // R8

endmodule

bind dac_pair_front dac_pair_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .upd_a      (upd_a),
    .upd_b_prst (upd_b_prst),
    .mode_q     (mode_q),
    .code_a     (code_a),
    .code_b     (code_b),
    .pwr_down   (pwr_down)
);

// File: tb/test_dac_pair_front.sv
`timescale 1ns/1ps
module test_dac_pair_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b1;
    logic        sleep = 1'b0;
    logic        wrt_a = 1'b0, wrt_b_sel = 1'b0, upd_a = 1'b0, upd_b_prst = 1'b0;
    logic [13:0] din_a = '0, din_b = '0;
    logic [13:0] code_a, code_b, code_a_n, code_b_n;
    logic        pwr_down;

    int n_vec = 0;
    int n_bad = 0;

    logic [13:0] hist_a [0:255];
    logic [13:0] hist_b [0:255];
    int ca = 0;
    int cb = 0;

    always #2.5 clk = ~clk;

    dac_pair_front i_dac_pair_front (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep(sleep),
        .wrt_a(wrt_a), .wrt_b_sel(wrt_b_sel), .upd_a(upd_a), .upd_b_prst(upd_b_prst),
        .din_a(din_a), .din_b(din_b), .code_a(code_a), .code_b(code_b),
        .code_a_n(code_a_n), .code_b_n(code_b_n), .pwr_down(pwr_down)
    );

    function automatic logic [13:0] wa(input int k);
        if (k == 1) return 14'd16383;
        if (k == 2) return 14'd0;
        return 14'((k * 2731 + 8191) % 16384);
    endfunction

    function automatic logic [13:0] wb(input int k);
        if (k == 3) return 14'd16383;
        if (k == 5) return 14'd8192;
        return 14'((k * 1559 + 5) % 16384);
    endfunction

    function automatic logic [13:0] xa(input int m);
        return 14'((m * 3001 + 77) % 16384);
    endfunction

    function automatic logic [13:0] xb(input int m);
        return 14'((m * 4093 + 16000) % 16384);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Code outputs plus complement relation (R10)
    task automatic chk_out(input string req, input int ea, input int eb);
        chk({req, " code_a"}, int'(code_a), ea);
        chk({req, " code_b"}, int'(code_b), eb);
        chk("R10 code_a_n", int'(code_a_n), 16383 - ea);
        chk("R10 code_b_n", int'(code_b_n), 16383 - eb);
    endtask

    function automatic int exp_a();
        return (ca >= 5) ? int'(hist_a[ca-5]) : 0;
    endfunction

    function automatic int exp_b();
        return (cb >= 5) ? int'(hist_b[cb-5]) : 0;
    endfunction

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; sleep = 1'b0;
        wrt_a = 0; wrt_b_sel = 0; upd_a = 0; upd_b_prst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Dual-bus beat: write and update strobes of a channel rise together
    task automatic dual_beat(input logic do_a, input logic do_b,
                             input logic [13:0] va, input logic [13:0] vb);
        @(negedge clk);
        din_a = va; din_b = vb;
        wrt_a = do_a; upd_a = do_a;
        wrt_b_sel = do_b; upd_b_prst = do_b;
        repeat (2) @(negedge clk);
        wrt_a = 0; upd_a = 0; wrt_b_sel = 0; upd_b_prst = 0;
        repeat (2) @(negedge clk);
    endtask

    // Shared-port slot: select settles first, then write and/or update rise
    task automatic il_slot(input logic [13:0] w, input logic s,
                           input logic do_wr, input logic do_up);
        @(negedge clk);
        din_a = w; din_b = ~w; wrt_b_sel = s;
        @(negedge clk);
        wrt_a = do_wr; upd_a = do_up;
        repeat (2) @(negedge clk);
        wrt_a = 0; upd_a = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [13:0] sa, sb, fa, fb;

        // ---------------- dual-bus mode ----------------
        do_reset(1'b1);
        chk_out("R12 reset dual", 0, 0);
        chk("R12 pwr_down", int'(pwr_down), 0);

        // R2 R3: both channels swept together
        for (int k = 0; k < 64; k++) begin
            hist_a[ca] = wa(k); ca++;
            hist_b[cb] = wb(k); cb++;
            dual_beat(1, 1, wa(k), wb(k));
            chk_out("R3 dual sweep", exp_a(), exp_b());
        end

        // R1: mode pin change after reset must not leave dual-bus mode
        mode_sel = 1'b0;
        // R3: channel B alone advances, A stays put
        for (int k = 64; k < 70; k++) begin
            hist_b[cb] = wb(k); cb++;
            dual_beat(0, 1, 14'h1555, wb(k));
            chk_out("R1 R3 B only", exp_a(), exp_b());
        end
        // R2 R3: channel A alone advances, B stays put
        for (int k = 70; k < 76; k++) begin
            hist_a[ca] = wa(k); ca++;
            dual_beat(1, 0, wa(k), 14'h2aaa);
            chk_out("R2 R3 A only", exp_a(), exp_b());
        end

        // R11: sleep freezes outputs, writes still captured
        fa = code_a; fb = code_b;
        @(negedge clk); sleep = 1'b1;
        @(negedge clk);
        chk("R11 pwr_down set", int'(pwr_down), 1);
        sa = '0; sb = '0;
        for (int k = 0; k < 3; k++) begin
            sa = wa(100 + k); sb = wb(100 + k);
            dual_beat(1, 1, sa, sb);
            chk_out("R11 frozen", int'(fa), int'(fb));
        end
        @(negedge clk); sleep = 1'b0;
        @(negedge clk);
        chk("R11 pwr_down clear", int'(pwr_down), 0);
        hist_a[ca-1] = sa;
        hist_b[cb-1] = sb;
        for (int k = 110; k < 118; k++) begin
            hist_a[ca] = wa(k); ca++;
            hist_b[cb] = wb(k); cb++;
            dual_beat(1, 1, wa(k), wb(k));
            chk_out("R11 resume", exp_a(), exp_b());
        end

        // ---------------- shared-port mode ----------------
        do_reset(1'b0);
        chk_out("R12 reset shared", 0, 0);
        mode_sel = 1'b1;  // R1: ignored after reset

        // R4 R6 R7 R9: alternating A/B slots, din_b carries junk
        for (int m = 0; m < 40; m++) begin
            il_slot(xa(m), 1'b1, 1'b1, 1'b1);
            if (m >= 4) chk_out("R9 R4 pair even", int'(xa(m-4)), int'(xb(m-4)));
            else        chk_out("R9 pre-fill", 0, 0);
            il_slot(xb(m), 1'b0, 1'b1, 1'b1);
            if (m >= 4) chk_out("R7 odd slot hold", int'(xa(m-4)), int'(xb(m-4)));
            else        chk_out("R7 pre-fill", 0, 0);
        end

        // R8: pairing reset blocks all updates
        fa = code_a; fb = code_b;
        @(negedge clk); upd_b_prst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            il_slot(14'd0, 1'b1, 1'b0, 1'b1);
            chk_out("R8 held", int'(fa), int'(fb));
        end
        @(negedge clk); upd_b_prst = 1'b0;
        @(negedge clk);

        // R8 R5: lone update shifts the phase; B register keeps xb(39)
        il_slot(14'd0, 1'b1, 1'b0, 1'b1);
        for (int j = 0; j < 8; j++) begin
            il_slot(xa(200 + j), 1'b1, 1'b1, 1'b1);
            il_slot(xb(200 + j), 1'b0, 1'b1, 1'b1);
            if (j == 2)
                chk_out("R8 shifted phase", int'(xa(39)), int'(xb(39)));
            else if (j == 3)
                chk_out("R5 B held", int'(xa(200)), int'(xb(39)));
            else if (j > 3)
                chk_out("R5 R8 misaligned pair", int'(xa(200 + j - 3)), int'(xb(200 + j - 4)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule